// File: doc/BRIEF.md
# UART register and command controller

This block is the host-side control core of a byte-oriented serial port. It sits on a simple memory-mapped register bus with a 6-bit byte offset. It holds two mode registers reached through a pointer that advances by itself, and it keeps the transmit holding byte and the enable state of both directions. It gathers the receive-side status from an external receive FIFO and latches the line error flags. It also decodes a packed command byte into three independent fields and drives one level-sensitive interrupt.

Transmit bytes leave the block as a one-cycle valid strobe with the byte, toward a serializer. Receive bytes come from a separate FIFO block: the core sees the FIFO fill level and head byte, and it answers with a pop strobe on a data read and a flush pulse on a receiver reset. Baud-rate generation, line serialization and parity live outside this block. The core only reflects the two divisor bytes it is given.

Top module: `uart_ctl_core`

## Requirements
- R1: After reset the status byte reads 0x08 (only transmitter-empty set), interrupt status and interrupt mask are 0, both mode registers read 0, the mode pointer selects the first register, and `irq` is low.
- R2: Offsets: 0x00 mode, 0x04 status (read), 0x08 command (write), 0x0C receive data (read) / transmit buffer (write), 0x14 interrupt status (read) / interrupt mask (write), 0x18 `div_msb` (read), 0x1C `div_lsb` (read). Any other read returns 0, and writes to offsets with no writable register change nothing.
- R3: A command byte is split as bits 6:4 miscellaneous, bits 3:2 transmitter, bits 1:0 receiver, with bit 7 ignored. In both enable fields 0 is no-op, 1 enable, 2 disable, 3 reserved. A reserved code changes no state and raises `cmd_err` for exactly the one cycle after the write.
- R4: A write to offset 0x00 stores into the register the pointer selects and then moves the pointer to the second register. Reads at 0x00 return the selected register. Miscellaneous code 1 returns the pointer to the first register.
- R5: A write to the transmit buffer latches the byte and clears transmitter-empty (status bit 3).
- R6: When the transmitter is enabled and not empty, the cycle after that state is reached `tx_valid` is high for one cycle carrying the held byte, and transmitter-empty is set. `tx_valid` is never raised from a cycle in which the transmitter was disabled.
- R7: Status bit 2 (transmitter-ready) equals the transmitter enable. Miscellaneous code 3 disables the transmitter, sets transmitter-empty and discards any held byte. An enable in the transmitter field of the same command is applied after that reset.
- R8: Status bit 0 is set when the FIFO level is non-zero and bit 1 when it equals the FIFO depth. A read of 0x0C with data returns the head byte and pulses `rx_pop` in that access; with an empty FIFO it returns 0 without a pop. The receiver field drives `rx_en`. Miscellaneous code 2 clears `rx_en` and pulses `rx_flush` for the cycle after the write.
- R9: Interrupt status bit 0 is transmitter-ready. Bit 1 is FIFO-full when bit 6 of the first mode register is set, otherwise receiver-ready. Bit 2 is the delta-break flag. `irq` is high whenever any interrupt status bit is set with its mask bit set, from the cycle after the mask write.
- R10: A `brk_evt` pulse sets the delta-break flag. Miscellaneous code 5 clears it, and a break event in the same cycle as the clear wins.
- R11: `line_err` bits {break, framing, parity, overrun} set sticky status bits {7,6,5,4}. Miscellaneous code 4 clears them, and a new error in the same cycle as the clear wins.
- R12: A transmit-buffer write in the same cycle as a send lets the old byte go out, latches the new byte and leaves transmitter-empty clear, so both bytes appear in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_head | input | 8 | Oldest byte in the receive FIFO |
| rx_pop | output | 1 | Remove the head byte (data read with data present) |
| rx_flush | output | 1 | One-cycle pulse to empty the receive FIFO |
| rx_en | output | 1 | Receiver enable toward the line side |
| brk_evt | input | 1 | Break detected on the line |
| line_err | input | 4 | {break, framing, parity, overrun} error pulses |
| div_msb | input | 8 | Baud divisor upper byte, read only |
| div_lsb | input | 8 | Baud divisor lower byte, read only |
| tx_valid | output | 1 | One-cycle transmit byte strobe |
| tx_data | output | 8 | Transmit byte, valid with tx_valid |
| cmd_err | output | 1 | Reserved command code seen |
| irq | output | 1 | Level interrupt |

## Verification
Three pairs of functions can land on the same clock edge. A transmit-buffer write can meet the send of the previous byte. A break event can meet the command that clears the delta-break flag. A line error can meet the error-clear command. The bench provokes each pair by writing back-to-back transmit bytes, and by driving the event input in the very cycle the command write is on the bus. It then judges the outcome at the ports: two strobes in consecutive cycles carrying the old and then the new byte, and the set flag surviving the clear in the interrupt or status read that follows.

// File: rtl/uart_ctl_pkg.sv
package uart_ctl_pkg;

   // byte offsets on the register bus
   localparam logic [5:0] OFS_MODE  = 6'h00;
   localparam logic [5:0] OFS_STAT  = 6'h04;
   localparam logic [5:0] OFS_CMD   = 6'h08;
   localparam logic [5:0] OFS_DATA  = 6'h0C;
   localparam logic [5:0] OFS_INT   = 6'h14;
   localparam logic [5:0] OFS_DIVHI = 6'h18;
   localparam logic [5:0] OFS_DIVLO = 6'h1C;

   typedef enum logic [2:0] {
      MISC_NOP     = 3'd0,
      MISC_PTR_RST = 3'd1,
      MISC_RX_RST  = 3'd2,
      MISC_TX_RST  = 3'd3,
      MISC_ERR_CLR = 3'd4,
      MISC_BRK_CLR = 3'd5,
      MISC_BRK_ON  = 3'd6,
      MISC_BRK_OFF = 3'd7
   } misc_op_e;

   typedef enum logic [1:0] {
      DIR_NOP  = 2'd0,
      DIR_ON   = 2'd1,
      DIR_OFF  = 2'd2,
      DIR_RSVD = 2'd3
   } dir_op_e;

   typedef struct packed {
      misc_op_e misc;
      dir_op_e  txop;
      dir_op_e  rxop;
   } cmd_fields_t;

   typedef struct packed {
      logic ptr_rst;
      logic rx_rst;
      logic tx_rst;
      logic err_clr;
      logic brk_clr;
      logic tx_on;
      logic tx_off;
      logic rx_on;
      logic rx_off;
      logic bad;
   } cmd_act_t;

endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
   import uart_ctl_pkg::*;
(
   input  logic       cmd_stb,
   input  logic [6:0] cmd_bits,
   output cmd_act_t   act
);

   cmd_fields_t f;

   always_comb begin
      f   = cmd_fields_t'(cmd_bits);
      act = '0;
      if (cmd_stb) begin
         case (f.misc)
            MISC_PTR_RST: act.ptr_rst = 1'b1;
            MISC_RX_RST:  act.rx_rst  = 1'b1;
            MISC_TX_RST:  act.tx_rst  = 1'b1;
            MISC_ERR_CLR: act.err_clr = 1'b1;
            MISC_BRK_CLR: act.brk_clr = 1'b1;
            default:      ;
         endcase
         case (f.txop)
            DIR_ON:   act.tx_on  = 1'b1;
            DIR_OFF:  act.tx_off = 1'b1;
            DIR_RSVD: act.bad    = 1'b1;
            default:  ;
         endcase
         case (f.rxop)
            DIR_ON:   act.rx_on  = 1'b1;
            DIR_OFF:  act.rx_off = 1'b1;
            DIR_RSVD: act.bad    = 1'b1;
            default:  ;
         endcase
      end
   end

endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              buf_wr,
   input  logic [DATA_W-1:0] buf_data,
   input  logic              en_set,
   input  logic              en_clr,
   input  logic              xmit_rst,
   output logic              tx_en,
   output logic              tx_empty,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data
);

   logic [DATA_W-1:0] hold_q;
   logic              send;

   assign send = tx_en & ~tx_empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_en    <= 1'b0;
         tx_empty <= 1'b1;
         hold_q   <= '0;
         tx_valid <= 1'b0;
         tx_data  <= '0;
      end else begin
         // reset is applied first, an enable in the same command after it
         if (en_set)
            tx_en <= 1'b1;
         else if (xmit_rst || en_clr)
            tx_en <= 1'b0;

         if (buf_wr)
            tx_empty <= 1'b0;
         else if (send || xmit_rst)
            tx_empty <= 1'b1;

         if (buf_wr)
            hold_q <= buf_data;

         tx_valid <= send;
         if (send)
            tx_data <= hold_q;
      end
   end

endmodule

// File: rtl/uart_irq_gen.sv
module uart_irq_gen (
   input  logic       tx_rdy,
   input  logic       rx_rdy,
   input  logic       rx_full,
   input  logic       rx_sel_full,
   input  logic       dbrk,
   input  logic [7:0] imr,
   output logic [7:0] isr,
   output logic       irq
);

   always_comb begin
      isr    = '0;
      isr[0] = tx_rdy;
      isr[1] = rx_sel_full ? rx_full : rx_rdy;
      isr[2] = dbrk;
      irq    = |(isr & imr);
   end

endmodule

// File: rtl/uart_ctl_core.sv
module uart_ctl_core
   import uart_ctl_pkg::*;
#(
   parameter  int ADDR_W     = 6,
   parameter  int FIFO_DEPTH = 4,
   parameter  int RX_SEL_BIT = 6,
   localparam int LVL_W      = $clog2(FIFO_DEPTH + 1),
   localparam int NUM_MODE   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic [LVL_W-1:0]  rx_level,
   input  logic [7:0]        rx_head,
   output logic              rx_pop,
   output logic              rx_flush,
   output logic              rx_en,
   input  logic              brk_evt,
   input  logic [3:0]        line_err,
   input  logic [7:0]        div_msb,
   input  logic [7:0]        div_lsb,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   output logic              cmd_err,
   output logic              irq
);

   // elaboration checks
   if (ADDR_W != 6) begin : g_bad_addr
      $error("uart_ctl_core: ADDR_W must be 6");
   end
   if (FIFO_DEPTH < 1) begin : g_bad_depth
      $error("uart_ctl_core: FIFO_DEPTH must be at least 1");
   end
   if (RX_SEL_BIT < 0 || RX_SEL_BIT > 7) begin : g_bad_sel
      $error("uart_ctl_core: RX_SEL_BIT out of range");
   end

   logic [5:0] ofs;
   logic       wr_acc, rd_acc;
   logic       mode_wr, cmd_stb, tbuf_wr, imr_wr;

   assign ofs     = bus_addr[5:0];
   assign wr_acc  = bus_sel & bus_wr;
   assign rd_acc  = bus_sel & ~bus_wr;
   assign mode_wr = wr_acc && (ofs == OFS_MODE);
   assign cmd_stb = wr_acc && (ofs == OFS_CMD);
   assign tbuf_wr = wr_acc && (ofs == OFS_DATA);
   assign imr_wr  = wr_acc && (ofs == OFS_INT);

   cmd_act_t act;

   uart_cmd_decode u_dec (
      .cmd_stb  (cmd_stb),
      .cmd_bits (bus_wdata[6:0]),
      .act      (act)
   );

   // mode registers behind an advancing pointer
   logic                          mode_ptr;
   logic [NUM_MODE-1:0][7:0]      mode_vec;

   for (genvar i = 0; i < NUM_MODE; i++) begin : g_mode
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (mode_wr && (mode_ptr == 1'(i)))
            q <= bus_wdata;
      end
      assign mode_vec[i] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mode_ptr <= 1'b0;
      else if (mode_wr)
         mode_ptr <= 1'b1;
      else if (act.ptr_rst)
         mode_ptr <= 1'b0;
   end

   // transmit path
   logic tx_en, tx_empty;

   uart_tx_hold #(.DATA_W(8)) u_tx (
      .clk      (clk),
      .rst_n    (rst_n),
      .buf_wr   (tbuf_wr),
      .buf_data (bus_wdata),
      .en_set   (act.tx_on),
      .en_clr   (act.tx_off),
      .xmit_rst (act.tx_rst),
      .tx_en    (tx_en),
      .tx_empty (tx_empty),
      .tx_valid (tx_valid),
      .tx_data  (tx_data)
   );

   // receive control, error and break flags, mask
   logic       rx_flush_q, cmd_err_q, dbrk_q;
   logic [3:0] err_q;
   logic [7:0] imr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_en      <= 1'b0;
         rx_flush_q <= 1'b0;
         cmd_err_q  <= 1'b0;
         dbrk_q     <= 1'b0;
         err_q      <= '0;
         imr_q      <= '0;
      end else begin
         if (act.rx_on)
            rx_en <= 1'b1;
         else if (act.rx_rst || act.rx_off)
            rx_en <= 1'b0;
         rx_flush_q <= act.rx_rst;
         cmd_err_q  <= act.bad;
         dbrk_q     <= (dbrk_q & ~act.brk_clr) | brk_evt;
         err_q      <= (err_q & {4{~act.err_clr}}) | line_err;
         if (imr_wr)
            imr_q <= bus_wdata;
      end
   end

   assign rx_flush = rx_flush_q;
   assign cmd_err  = cmd_err_q;

   logic rx_rdy, rx_full;
   logic [7:0] status, isr;

   assign rx_rdy  = (rx_level != '0);
   assign rx_full = (rx_level == LVL_W'(FIFO_DEPTH));
   assign status  = {err_q, tx_empty, tx_en, rx_full, rx_rdy};

   uart_irq_gen u_irq (
      .tx_rdy      (tx_en),
      .rx_rdy      (rx_rdy),
      .rx_full     (rx_full),
      .rx_sel_full (mode_vec[0][RX_SEL_BIT]),
      .dbrk        (dbrk_q),
      .imr         (imr_q),
      .isr         (isr),
      .irq         (irq)
   );

   // read side
   assign rx_pop = rd_acc && (ofs == OFS_DATA) && rx_rdy;

   always_comb begin
      bus_rdata = '0;
      if (rd_acc) begin
         case (ofs)
            OFS_MODE:  bus_rdata = mode_vec[mode_ptr];
            OFS_STAT:  bus_rdata = status;
            OFS_DATA:  bus_rdata = rx_rdy ? rx_head : 8'h00;
            OFS_INT:   bus_rdata = isr;
            OFS_DIVHI: bus_rdata = div_msb;
            OFS_DIVLO: bus_rdata = div_lsb;
            default:   bus_rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/uart_ctl_core_chk.sv
module uart_ctl_core_chk #(
   parameter int ADDR_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [7:0]        bus_wdata,
   input logic              tx_en,
   input logic              tx_empty,
   input logic              tx_valid,
   input logic              irq,
   input logic [7:0]        imr_q,
   input logic              mode_ptr,
   input logic              brk_evt,
   input logic              dbrk_q
);

   logic wr_at;
   assign wr_at = bus_sel & bus_wr;

   // R4
   mode_ptr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_at && bus_addr[5:0] == 6'h00) |=> mode_ptr);

   // R5
   tx_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_at && bus_addr[5:0] == 6'h0C) |=> !tx_empty);

   // R6
   tx_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && !tx_empty) |=> tx_valid);

   // R6
   tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> $past(tx_en));

   // R7
   tx_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_at && bus_addr[5:0] == 6'h08 && bus_wdata[6:4] == 3'd3 && bus_wdata[3:2] != 2'd1)
      |=> (!tx_en && tx_empty));

   // R9
   irq_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && imr_q[0]) |-> irq);

   // R9
   irq_brk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dbrk_q && imr_q[2]) |-> irq);

   // R10
   brk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      brk_evt |=> dbrk_q);

endmodule

bind uart_ctl_core uart_ctl_core_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .tx_en     (tx_en),
   .tx_empty  (tx_empty),
   .tx_valid  (tx_valid),
   .irq       (irq),
   .imr_q     (imr_q),
   .mode_ptr  (mode_ptr),
   .brk_evt   (brk_evt),
   .dbrk_q    (dbrk_q)
);

// File: tb/uart_ctl_core_bench.sv
module uart_ctl_core_bench;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       bus_sel, bus_wr;
   logic [5:0] bus_addr;
   logic [7:0] bus_wdata, bus_rdata;
   logic [2:0] rx_level;
   logic [7:0] rx_head;
   logic       rx_pop, rx_flush, rx_en;
   logic       brk_evt;
   logic [3:0] line_err;
   logic [7:0] div_msb, div_lsb;
   logic       tx_valid;
   logic [7:0] tx_data;
   logic       cmd_err, irq;

   always #10 clk = ~clk;

   uart_ctl_core u_uart_ctl_core (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_level(rx_level), .rx_head(rx_head), .rx_pop(rx_pop),
      .rx_flush(rx_flush), .rx_en(rx_en), .brk_evt(brk_evt),
      .line_err(line_err), .div_msb(div_msb), .div_lsb(div_lsb),
      .tx_valid(tx_valid), .tx_data(tx_data), .cmd_err(cmd_err), .irq(irq)
   );

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // callers are at a negedge; returns at the next negedge
   task automatic wr(input logic [5:0] a, input logic [7:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [7:0] d, output logic pop);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1;
      d = bus_rdata; pop = rx_pop;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic t_reset;
      logic [7:0] d; logic p;
      rd(6'h04, d, p); chk("R1 status", d, 8'h08);
      rd(6'h14, d, p); chk("R1 isr", d, 8'h00);
      rd(6'h00, d, p); chk("R1 mode0", d, 8'h00);
      chk("R1 irq", irq, 1'b0);
   endtask

   task automatic t_mode_ptr;
      logic [7:0] d; logic p;
      wr(6'h00, 8'h40);
      wr(6'h00, 8'h13);
      rd(6'h00, d, p); chk("R4 second reg", d, 8'h13);
      wr(6'h00, 8'h22);
      rd(6'h00, d, p); chk("R4 stays second", d, 8'h22);
      wr(6'h08, 8'h10);
      rd(6'h00, d, p); chk("R4 ptr reset", d, 8'h40);
   endtask

   task automatic t_tx_basic;
      logic [7:0] d; logic p;
      wr(6'h0C, 8'h5A);
      rd(6'h04, d, p); chk("R5 empty cleared", d, 8'h00);
      chk("R6 no send disabled", tx_valid, 1'b0);
      wr(6'h08, 8'h84);               // bit 7 ignored: tx enable (R3)
      chk("R6 not yet", tx_valid, 1'b0);
      @(negedge clk);
      chk("R6 strobe", tx_valid, 1'b1);
      chk("R6 data", tx_data, 8'h5A);
      rd(6'h04, d, p); chk("R7 status enabled", d, 8'h0C);
      chk("R6 one cycle", tx_valid, 1'b0);
   endtask

   task automatic t_tx_collide;
      logic [7:0] d; logic p;
      wr(6'h0C, 8'hA1);
      wr(6'h0C, 8'hB2);
      chk("R12 first strobe", {tx_valid, tx_data}, {1'b1, 8'hA1});
      @(negedge clk);
      chk("R12 second strobe", {tx_valid, tx_data}, {1'b1, 8'hB2});
      @(negedge clk);
      chk("R12 idle", tx_valid, 1'b0);
      rd(6'h04, d, p); chk("R12 status", d, 8'h0C);
   endtask

   task automatic t_tx_control;
      logic [7:0] d; logic p; int pulses;
      wr(6'h08, 8'h08);
      rd(6'h04, d, p); chk("R7 disabled", d, 8'h08);
      wr(6'h0C, 8'h33);
      pulses = 0;
      for (int i = 0; i < 3; i++) begin
         if (tx_valid) pulses++;
         @(negedge clk);
      end
      chk("R6 held while disabled", pulses, 0);
      wr(6'h08, 8'h34);               // reset tx then enable
      pulses = 0;
      for (int i = 0; i < 3; i++) begin
         if (tx_valid) pulses++;
         @(negedge clk);
      end
      chk("R7 byte discarded", pulses, 0);
      rd(6'h04, d, p); chk("R7 reset+enable status", d, 8'h0C);
   endtask

   task automatic t_reserved;
      logic [7:0] d; logic p;
      wr(6'h08, 8'h0C);
      chk("R3 tx reserved err", cmd_err, 1'b1);
      rd(6'h04, d, p); chk("R3 tx state kept", d[2], 1'b1);
      chk("R3 err one cycle", cmd_err, 1'b0);
      wr(6'h08, 8'h03);
      chk("R3 rx reserved err", cmd_err, 1'b1);
      chk("R3 rx state kept", rx_en, 1'b0);
   endtask

   task automatic t_irq_mask;
      logic [7:0] d; logic p;
      chk("R9 masked", irq, 1'b0);
      wr(6'h14, 8'h01);
      chk("R9 tx irq", irq, 1'b1);
      rd(6'h14, d, p); chk("R9 isr tx", d, 8'h01);
      wr(6'h14, 8'h00);
      chk("R9 unmask off", irq, 1'b0);
   endtask

   task automatic t_rx;
      logic [7:0] d; logic p;
      wr(6'h08, 8'h10); wr(6'h00, 8'h00);
      rx_level = 3'd1; rx_head = 8'h77;
      rd(6'h14, d, p); chk("R9 rx ready source", d, 8'h03);
      wr(6'h08, 8'h10); wr(6'h00, 8'h40);
      rd(6'h14, d, p); chk("R9 full source not full", d, 8'h01);
      rx_level = 3'd4;
      rd(6'h14, d, p); chk("R9 full source full", d, 8'h03);
      rd(6'h04, d, p); chk("R8 status full", d, 8'h0F);
      wr(6'h14, 8'h02);
      chk("R9 rx irq", irq, 1'b1);
      wr(6'h14, 8'h00);
      rx_level = 3'd2;
      rd(6'h0C, d, p); chk("R8 head read", {p, d}, {1'b1, 8'h77});
      rx_level = 3'd0;
      rd(6'h0C, d, p); chk("R8 empty read", {p, d}, {1'b0, 8'h00});
      wr(6'h08, 8'h01); chk("R8 rx enable", rx_en, 1'b1);
      wr(6'h08, 8'h02); chk("R8 rx disable", rx_en, 1'b0);
      wr(6'h08, 8'h01);
      wr(6'h08, 8'h20);
      chk("R8 rx reset flush", {rx_en, rx_flush}, {1'b0, 1'b1});
      @(negedge clk);
      chk("R8 flush one cycle", rx_flush, 1'b0);
   endtask

   task automatic t_break;
      logic [7:0] d; logic p;
      brk_evt = 1'b1; @(negedge clk); brk_evt = 1'b0;
      rd(6'h14, d, p); chk("R10 break set", d[2], 1'b1);
      wr(6'h08, 8'h50);
      rd(6'h14, d, p); chk("R10 break cleared", d[2], 1'b0);
      brk_evt = 1'b1;
      wr(6'h08, 8'h50);
      brk_evt = 1'b0;
      rd(6'h14, d, p); chk("R10 set wins", d[2], 1'b1);
      wr(6'h08, 8'h50);
   endtask

   task automatic t_errors;
      logic [7:0] d; logic p;
      line_err = 4'b0101; @(negedge clk); line_err = 4'b0000;
      rd(6'h04, d, p); chk("R11 sticky", d[7:4], 4'b0101);
      wr(6'h08, 8'h40);
      rd(6'h04, d, p); chk("R11 cleared", d[7:4], 4'b0000);
      line_err = 4'b1000;
      wr(6'h08, 8'h40);
      line_err = 4'b0000;
      rd(6'h04, d, p); chk("R11 set wins", d[7:4], 4'b1000);
   endtask

   task automatic t_map;
      logic [7:0] d, s0, m0; logic p;
      rd(6'h18, d, p); chk("R2 div msb", d, 8'hA5);
      rd(6'h1C, d, p); chk("R2 div lsb", d, 8'h3C);
      rd(6'h10, d, p); chk("R2 unlisted read", d, 8'h00);
      rd(6'h08, d, p); chk("R2 cmd not readable", d, 8'h00);
      rd(6'h04, s0, p);
      rd(6'h00, m0, p);
      wr(6'h04, 8'hFF); wr(6'h10, 8'hFF); wr(6'h18, 8'hFF); wr(6'h24, 8'hFF);
      rd(6'h04, d, p); chk("R2 writes ignored status", d, s0);
      rd(6'h00, d, p); chk("R2 writes ignored mode", d, m0);
      chk("R2 writes ignored irq", irq, 1'b0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
      rx_level = '0; rx_head = '0; brk_evt = 1'b0; line_err = '0;
      div_msb = 8'hA5; div_lsb = 8'h3C;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset;
      t_mode_ptr;
      t_tx_basic;
      t_tx_collide;
      t_tx_control;
      t_reserved;
      t_irq_mask;
      t_rx;
      t_break;
      t_errors;
      t_map;
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule